// File: doc/BRIEF.md
# Post-Modify Address Generator

This block computes the effective address of a single load or store in a DSP-style memory pipe. For the modes that change the base register, it also computes the value written back to that register. A mode select picks the addressing form. The forms include:

- plain offset, indexed and scaled-absolute forms, which leave the base alone;
- an absolute-set form, which also writes the immediate to a second destination;
- three post-increment forms (by register, by immediate, and bit-reversed);
- two circular-buffer forms, which wrap the updated base inside a window set by a start register and a length.

All arithmetic is combinational. A single register stage then presents the results one cycle after a valid request. Decode, the register file and the memory access are done by neighbouring blocks.

The 32-bit modifier register has three fields. Bits 16:0 hold the circular buffer length. Bits 31:28 and 23:17, concatenated in that order, form an 11-bit signed increment field for the circular-register mode. Bits 27:24 are not used by the circular logic.

Top module: `lsu_agu`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs read zero after that edge.
- R2: Mode 0 (offset): the address is base + imm, and neither write enable is set.
- R3: Mode 1 (indexed): the address is base + (index << shamt), and neither write enable is set.
- R4: Mode 2 (scaled absolute): the address is (index << shamt) + imm, and neither write enable is set.
- R5: Mode 3 (absolute set): the address is imm, the extra destination enable is set with value imm, and the base is not written.
- R6: Mode 4 (post-increment by register): the address is the old base, and the base is written with base + modifier.
- R7: Mode 5 (post-increment by immediate): the address is the old base, and the base is written with base + imm.
- R8: Mode 6 (bit-reverse): the address is the base with bits 15:0 mirrored (bit i takes bit 15-i) and bits 31:16 unchanged. The base is written with base + modifier.
- R9: Modes 7 and 8 (circular): the address is the old base, and the base is written with base + incr. Let rel = base - start + incr. The length (modifier bits 16:0) is subtracted when rel >= length, and added when rel < 0.
- R10: In mode 8 the circular increment is the sign-extended field {modifier[31:28], modifier[23:17]} shifted left by size (0 byte, 1 half, 2 word, 3 doubleword).
- R11: In mode 7 the circular increment is imm.
- R12: Results appear one cycle after `in_valid`. A cycle without `in_valid` gives `out_valid` low and both write enables low.
- R13: Mode codes 9 to 15 give address zero and no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing mode code |
| size_log2 | input | 2 | log2 of access size in bytes |
| base | input | 32 | Base register value |
| modifier | input | 32 | Modifier register (length, increment field) |
| circ_start | input | 32 | Circular buffer start address |
| index | input | 32 | Index / scaled register |
| shamt | input | 2 | Left shift for index |
| imm | input | 32 | Extended immediate |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Effective address |
| out_base_we | output | 1 | Base write enable |
| out_base_new | output | 32 | Updated base value |
| out_extra_we | output | 1 | Extra destination write enable |
| out_extra_val | output | 32 | Extra destination value |

## Verification
On every cycle, the assertions check several properties:
- the one-cycle latency and the quiet write enables on idle cycles;
- that the post-modify and circular forms issue the old base as the address;
- the fixed upper half and mirrored end bits of the bit-reversed address;
- that a circular update starting inside the window with an increment no larger than the length stays inside the window.

The exact arithmetic needs the bench's directed scenarios. These cover:
- the wrap amounts at both buffer edges;
- the increment field scaled by each access size;
- negative offsets;
- the unused mode codes.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;

    localparam int XLEN     = 32;
    localparam int LEN_W    = 17;
    localparam int IF_HI_W  = 4;
    localparam int IF_LO_W  = 7;
    localparam int IF_W     = IF_HI_W + IF_LO_W;
    localparam int REV_BITS = 16;
    localparam int SH_W     = 2;
    localparam int MODE_W   = 4;

    typedef enum logic [MODE_W-1:0] {
        M_OFFSET     = 4'd0,
        M_INDEXED    = 4'd1,
        M_SCALED_ABS = 4'd2,
        M_ABS_SET    = 4'd3,
        M_POST_REG   = 4'd4,
        M_POST_IMM   = 4'd5,
        M_BITREV     = 4'd6,
        M_CIRC_IMM   = 4'd7,
        M_CIRC_REG   = 4'd8
    } agu_mode_e;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic            base_we;
        logic [XLEN-1:0] base_new;
        logic            extra_we;
        logic [XLEN-1:0] extra_val;
    } agu_result_t;

    // Signed increment field, sign extended and scaled by access size.
    function automatic logic [XLEN-1:0] ifield_incr(
        input logic [IF_HI_W-1:0] hi,
        input logic [IF_LO_W-1:0] lo,
        input logic [SH_W-1:0]    sz
    );
        logic signed [IF_W-1:0] f;
        logic        [XLEN-1:0] wide;
        f    = {hi, lo};
        wide = XLEN'(f);
        return wide << sz;
    endfunction

    function automatic logic is_circ(input agu_mode_e m);
        return (m == M_CIRC_IMM) || (m == M_CIRC_REG);
    endfunction

endpackage

// File: rtl/lsu_agu_bitrev.sv
module lsu_agu_bitrev #(
    parameter int W        = lsu_agu_pkg::XLEN,
    parameter int REV_BITS = lsu_agu_pkg::REV_BITS
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int UPPER = W - REV_BITS;

    for (genvar i = 0; i < REV_BITS; i++) begin : g_rev
        assign dout[i] = din[REV_BITS-1-i];
    end

    if (UPPER > 0) begin : g_pass
        assign dout[W-1:REV_BITS] = din[W-1:REV_BITS];
    end
endmodule

// File: rtl/lsu_agu_circ_add.sv
module lsu_agu_circ_add #(
    parameter int W     = lsu_agu_pkg::XLEN,
    parameter int LEN_W = lsu_agu_pkg::LEN_W
) (
    input  logic [W-1:0]     base,
    input  logic [W-1:0]     incr,
    input  logic [W-1:0]     start,
    input  logic [LEN_W-1:0] len,
    output logic [W-1:0]     result
);
    localparam int RW = W + 2;

    logic signed [RW-1:0] rel;
    logic signed [RW-1:0] len_rel;
    logic        [W-1:0]  len_w;
    logic        [W-1:0]  sum;
    logic                 wrap_hi;
    logic                 wrap_lo;

    always_comb begin
        // Position of the updated pointer relative to the window start.
        rel     = $signed({2'b00, base}) - $signed({2'b00, start})
                + $signed({{2{incr[W-1]}}, incr});
        len_rel = $signed(RW'(len));
        len_w   = W'(len);
        sum     = base + incr;
        wrap_hi = (rel >= len_rel);
        wrap_lo = (rel < 0);
        if (wrap_hi)      result = sum - len_w;
        else if (wrap_lo) result = sum + len_w;
        else              result = sum;
    end
endmodule

// File: rtl/lsu_agu_mode_mux.sv
module lsu_agu_mode_mux
    import lsu_agu_pkg::*;
(
    input  agu_mode_e          mode,
    input  logic [SH_W-1:0]    size_log2,
    input  logic [XLEN-1:0]    base,
    input  logic [XLEN-1:0]    modifier,
    input  logic [XLEN-1:0]    circ_start,
    input  logic [XLEN-1:0]    index,
    input  logic [SH_W-1:0]    shamt,
    input  logic [XLEN-1:0]    imm,
    output agu_result_t        res
);
    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] rev_addr;
    logic [XLEN-1:0] reg_incr;
    logic [XLEN-1:0] circ_incr;
    logic [XLEN-1:0] circ_next;

    assign scaled    = index << shamt;
    assign reg_incr  = ifield_incr(modifier[31:28], modifier[23:17], size_log2);
    assign circ_incr = (mode == M_CIRC_REG) ? reg_incr : imm;

    lsu_agu_bitrev #(.W(XLEN), .REV_BITS(REV_BITS)) u_rev (
        .din  (base),
        .dout (rev_addr)
    );

    lsu_agu_circ_add #(.W(XLEN), .LEN_W(LEN_W)) u_circ (
        .base   (base),
        .incr   (circ_incr),
        .start  (circ_start),
        .len    (modifier[LEN_W-1:0]),
        .result (circ_next)
    );

    always_comb begin
        res = '0;
        case (mode)
            M_OFFSET:     res.addr = base + imm;
            M_INDEXED:    res.addr = base + scaled;
            M_SCALED_ABS: res.addr = scaled + imm;
            M_ABS_SET: begin
                res.addr      = imm;
                res.extra_we  = 1'b1;
                res.extra_val = imm;
            end
            M_POST_REG: begin
                res.addr     = base;
                res.base_we  = 1'b1;
                res.base_new = base + modifier;
            end
            M_POST_IMM: begin
                res.addr     = base;
                res.base_we  = 1'b1;
                res.base_new = base + imm;
            end
            M_BITREV: begin
                res.addr     = rev_addr;
                res.base_we  = 1'b1;
                res.base_new = base + modifier;
            end
            M_CIRC_IMM, M_CIRC_REG: begin
                res.addr     = base;
                res.base_we  = 1'b1;
                res.base_new = circ_next;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
    import lsu_agu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [MODE_W-1:0]    mode,
    input  logic [SH_W-1:0]      size_log2,
    input  logic [XLEN-1:0]      base,
    input  logic [XLEN-1:0]      modifier,
    input  logic [XLEN-1:0]      circ_start,
    input  logic [XLEN-1:0]      index,
    input  logic [SH_W-1:0]      shamt,
    input  logic [XLEN-1:0]      imm,
    output logic                 out_valid,
    output logic [XLEN-1:0]      out_addr,
    output logic                 out_base_we,
    output logic [XLEN-1:0]      out_base_new,
    output logic                 out_extra_we,
    output logic [XLEN-1:0]      out_extra_val
);
    agu_mode_e   mode_e;
    agu_result_t res_d;
    agu_result_t res_q;
    logic        valid_q;

    assign mode_e = agu_mode_e'(mode);

    lsu_agu_mode_mux u_mux (
        .mode       (mode_e),
        .size_log2  (size_log2),
        .base       (base),
        .modifier   (modifier),
        .circ_start (circ_start),
        .index      (index),
        .shamt      (shamt),
        .imm        (imm),
        .res        (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            res_q   <= in_valid ? res_d : '0;
        end
    end

    assign out_valid     = valid_q;
    assign out_addr      = res_q.addr;
    assign out_base_we   = res_q.base_we;
    assign out_base_new  = res_q.base_new;
    assign out_extra_we  = res_q.extra_we;
    assign out_extra_val = res_q.extra_val;

    // Precondition for the window check: pointer inside window, |incr| <= len.
    logic [XLEN-1:0] chk_incr;
    logic [XLEN-1:0] chk_abs;
    logic [XLEN-1:0] chk_len;
    logic            chk_in_win;
    always_comb begin
        chk_incr   = (mode_e == M_CIRC_REG)
                   ? ifield_incr(modifier[31:28], modifier[23:17], size_log2) : imm;
        chk_abs    = chk_incr[XLEN-1] ? (~chk_incr + 1'b1) : chk_incr;
        chk_len    = XLEN'(modifier[LEN_W-1:0]);
        chk_in_win = (base >= circ_start) && ((base - circ_start) < chk_len)
                   && (chk_abs <= chk_len);
    end

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !out_base_we && !out_extra_we);

    a_r2_offset_nowrite: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_e == M_OFFSET) |=> out_valid && !out_base_we && !out_extra_we);

    a_r5_abs_set_extra: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_e == M_ABS_SET)
        |=> out_extra_we && (out_extra_val == out_addr) && !out_base_we);

    a_r6_post_old_base: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (mode_e == M_POST_REG || mode_e == M_POST_IMM || is_circ(mode_e)))
        |=> out_base_we && (out_addr == $past(base)));

    a_r8_bitrev_shape: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_e == M_BITREV)
        |=> (out_addr[31:16] == $past(base[31:16])) && (out_addr[0] == $past(base[15]))
            && (out_addr[15] == $past(base[0])));

    a_r9_circ_in_window: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_circ(mode_e) && chk_in_win)
        |=> ((out_base_new - $past(circ_start)) < $past(chk_len)));

    a_r13_unused_mode: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode > 4'd8)
        |=> !out_base_we && !out_extra_we && (out_addr == '0));
endmodule

// File: tb/test_lsu_agu.sv
`timescale 1ns/1ps
module test_lsu_agu;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  mode;
    logic [1:0]  size_log2;
    logic [31:0] base, modifier, circ_start, index, imm;
    logic [1:0]  shamt;
    logic        out_valid, out_base_we, out_extra_we;
    logic [31:0] out_addr, out_base_new, out_extra_val;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    lsu_agu i_lsu_agu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .size_log2(size_log2), .base(base), .modifier(modifier),
        .circ_start(circ_start), .index(index), .shamt(shamt), .imm(imm),
        .out_valid(out_valid), .out_addr(out_addr), .out_base_we(out_base_we),
        .out_base_new(out_base_new), .out_extra_we(out_extra_we),
        .out_extra_val(out_extra_val)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] mk_mod(input logic [10:0] f, input logic [16:0] len);
        return {f[10:7], 4'b0000, f[6:0], len};
    endfunction

    function automatic logic [31:0] exp_circ(input logic [31:0] b, input logic [31:0] inc,
                                             input logic [31:0] st, input logic [16:0] len);
        longint rel;
        logic [31:0] s;
        rel = longint'(b) - longint'(st) + longint'($signed(inc));
        s   = b + inc;
        if (rel >= longint'(len)) return s - 32'(len);
        if (rel < 0)              return s + 32'(len);
        return s;
    endfunction

    task automatic issue(input logic [3:0] m, input logic [31:0] b, input logic [31:0] md,
                         input logic [31:0] st, input logic [31:0] ix, input logic [1:0] sh,
                         input logic [1:0] sz, input logic [31:0] im);
        @(negedge clk);
        in_valid = 1'b1; mode = m; base = b; modifier = md; circ_start = st;
        index = ix; shamt = sh; size_log2 = sz; imm = im;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; mode = 4'd4; base = 32'h1234; modifier = 32'h10;
        @(negedge clk);
        @(negedge clk);
        chk("R1 valid", {31'b0, out_valid}, 32'd0);
        chk("R1 addr", out_addr, 32'd0);
        chk("R1 base_we", {31'b0, out_base_we}, 32'd0);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    task automatic t_plain;
        issue(4'd0, 32'h2000_0000, 0, 0, 0, 0, 0, 32'hFFFF_FFFC);
        chk("R2 addr", out_addr, 32'h1FFF_FFFC);
        chk("R2 we", {30'b0, out_base_we, out_extra_we}, 32'd0);
        chk("R12 valid", {31'b0, out_valid}, 32'd1);
        issue(4'd1, 32'h100, 0, 0, 32'h10, 2'd3, 0, 32'h55);
        chk("R3 addr", out_addr, 32'h180);
        chk("R3 we", {30'b0, out_base_we, out_extra_we}, 32'd0);
        issue(4'd2, 32'h999, 0, 0, 32'd5, 2'd2, 0, 32'h4000);
        chk("R4 addr", out_addr, 32'h4014);
    endtask

    task automatic t_abs_set;
        issue(4'd3, 32'h77, 0, 0, 0, 0, 0, 32'hDEAD_0000);
        chk("R5 addr", out_addr, 32'hDEAD_0000);
        chk("R5 extra", out_extra_val, 32'hDEAD_0000);
        chk("R5 we", {30'b0, out_base_we, out_extra_we}, 32'd1);
    endtask

    task automatic t_post;
        issue(4'd4, 32'h500, 32'hFFFF_FFF0, 0, 0, 0, 0, 0);
        chk("R6 addr", out_addr, 32'h500);
        chk("R6 base", out_base_new, 32'h4F0);
        chk("R6 we", {31'b0, out_base_we}, 32'd1);
        issue(4'd5, 32'h500, 32'h4, 0, 0, 0, 0, 32'd8);
        chk("R7 addr", out_addr, 32'h500);
        chk("R7 base", out_base_new, 32'h508);
    endtask

    task automatic t_bitrev;
        logic [31:0] b;
        logic [31:0] e;
        b = 32'hABCD_0001;
        e = b;
        for (int i = 0; i < 16; i++) e[i] = b[15 - i];
        issue(4'd6, b, 32'h100, 0, 0, 0, 0, 0);
        chk("R8 addr", out_addr, e);
        chk("R8 base", out_base_new, 32'hABCD_0101);
        b = 32'h0000_3C5A;
        e = b;
        for (int i = 0; i < 16; i++) e[i] = b[15 - i];
        issue(4'd6, b, 32'h2, 0, 0, 0, 0, 0);
        chk("R8 addr2", out_addr, e);
    endtask

    task automatic t_circ_imm;
        logic [31:0] md;
        md = mk_mod(11'd0, 17'h100);
        issue(4'd7, 32'h10F0, md, 32'h1000, 0, 0, 0, 32'h20);
        chk("R9 addr", out_addr, 32'h10F0);
        chk("R9 wrap high", out_base_new, 32'h1010);
        issue(4'd7, 32'h1008, md, 32'h1000, 0, 0, 0, 32'hFFFF_FFF0);
        chk("R9 wrap low", out_base_new, 32'h10F8);
        issue(4'd7, 32'h1010, md, 32'h1000, 0, 0, 0, 32'd8);
        chk("R11 no wrap", out_base_new, 32'h1018);
        issue(4'd7, 32'h10F8, md, 32'h1000, 0, 0, 0, 32'd8);
        chk("R9 exact end", out_base_new, exp_circ(32'h10F8, 32'd8, 32'h1000, 17'h100));
    endtask

    task automatic t_circ_reg;
        logic [31:0] md;
        md = mk_mod(11'd3, 17'h100);
        for (int sz = 0; sz < 4; sz++) begin
            issue(4'd8, 32'h1010, md, 32'h1000, 0, 0, 2'(sz), 32'h7777);
            chk("R10 scaled incr", out_base_new, 32'h1010 + (32'd3 << sz));
        end
        md = mk_mod(11'h7FF, 17'h100);
        issue(4'd8, 32'h1004, md, 32'h1000, 0, 0, 2'd3, 0);
        chk("R10 negative wrap", out_base_new,
            exp_circ(32'h1004, 32'hFFFF_FFF8, 32'h1000, 17'h100));
        chk("R10 negative value", out_base_new, 32'h10FC);
    endtask

    task automatic t_idle_unused;
        @(negedge clk);
        in_valid = 1'b0; mode = 4'd4; base = 32'h40;
        @(negedge clk);
        chk("R12 idle valid", {31'b0, out_valid}, 32'd0);
        chk("R12 idle we", {30'b0, out_base_we, out_extra_we}, 32'd0);
        issue(4'd12, 32'h40, 32'h4, 0, 0, 0, 0, 32'h8);
        chk("R13 addr", out_addr, 32'd0);
        chk("R13 we", {30'b0, out_base_we, out_extra_we}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; mode = 0; size_log2 = 0; base = 0; modifier = 0;
        circ_start = 0; index = 0; shamt = 0; imm = 0;
        t_reset();
        t_plain();
        t_abs_set();
        t_post();
        t_bitrev();
        t_circ_imm();
        t_circ_reg();
        t_idle_unused();
        @(negedge clk);
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule